// File: doc/BRIEF.md
# Ring-Buffer Sample Memory Addresser

This block forms the addresses that a sample-processing engine uses to reach its 16-bit external sample RAM. The engine runs a fixed program of `STEP_N` steps per audio sample, one step per active cycle. On each step the block takes the instruction's memory fields and builds a word address. It starts from an entry of a small offset table and can add a masked copy of an address register and an increment of one. It then either wraps the result inside a circular buffer that moves by one word per sample, or keeps it as an absolute table address. The word address is then turned into a byte address relative to a buffer base pointer.

The block also owns the per-sample ring counter, and it issues RAM reads and writes only on odd steps. Read data comes back one cycle after the request. The block sign-extends it to 24 bits and parks it in one of four staging slots, so that a later step can copy it into the engine's memory-staging registers. Writes store the engine's 24-bit result, truncated to 16 bits.

Top module: `rbuf_mem_addr`

## Requirements
- R1: After reset the ring counter reads 1, all four staging slots hold 0, every offset table entry is 0, and no RAM access or staging copy is signalled.
- R2: A write through the offset table port sets the entry at `offs_waddr_i` on that clock edge. Each address starts from the entry that `offs_sel_i` selects.
- R3: When `adrs_add_i` is set, bits [11:0] of `adrs_i` are added to the word address. When `next_adr_i` is set, 1 is added. Both additions are modulo 2^16.
- R4: When `abs_table_i` is 0, the low 16 bits of the ring counter are added, and the sum is ANDed with `ring_mask_i`.
- R5: When `abs_table_i` is 1, the word address is kept modulo 2^16 and the ring counter is not used.
- R6: `ram_addr_o` equals (2 × word address + `base_ptr_i`) modulo 2^BYTE_AW.
- R7: A RAM access is issued only when `step_valid_i` is 1 and `step_i[0]` is 1. On even steps, `rd_en_i` and `wr_en_i` have no effect on `ram_rd_o` or `ram_we_o`.
- R8: On an issued write, `ram_we_o` is 1 and `ram_wdata_o` equals `wr_data_i[15:0]`.
- R9: A read issued on step s sign-extends `ram_rdata_i`, sampled one cycle later, into slot (s+2) mod 4. While `step_valid_i` and `stage_ld_i` are both 1, `mems_we_o` is 1, `mems_idx_o` equals `stage_idx_i`, and `mems_data_o` equals slot `step_i` mod 4.
- R10: On the clock edge that ends a valid step `STEP_N`-1, the ring counter drops by one. If that would make it 0, it loads `ring_mask_i`+1 instead. An access on that same step still uses the value from before the update.
- R11: When `rd_en_i` and `wr_en_i` are both set on an odd step, only the write is issued and no staging slot is loaded.
- R12: While `step_valid_i` is 0, no access or staging copy is signalled and the ring counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| offs_we_i | input | 1 | Offset table write enable |
| offs_waddr_i | input | OFFS_IW | Offset table write index |
| offs_wdata_i | input | RING_W | Offset table write data |
| ring_mask_i | input | RING_W | Ring length minus one, used as a mask |
| base_ptr_i | input | BYTE_AW | Buffer base, as a byte address |
| step_valid_i | input | 1 | A program step executes this cycle |
| step_i | input | STEP_W | Step index within the sample |
| offs_sel_i | input | OFFS_IW | Offset table entry for this step |
| adrs_add_i | input | 1 | Add the masked address register |
| next_adr_i | input | 1 | Add one word |
| abs_table_i | input | 1 | Absolute table address, no ring wrap |
| rd_en_i | input | 1 | Memory read request |
| wr_en_i | input | 1 | Memory write request |
| stage_ld_i | input | 1 | Copy a staging slot to a staging register |
| stage_idx_i | input | MEMS_IW | Target staging register |
| adrs_i | input | ADRS_W | Address register value |
| wr_data_i | input | DATA_W | Result to write |
| ram_rd_o | output | 1 | RAM read strobe |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | BYTE_AW | RAM byte address |
| ram_wdata_o | output | SMP_W | RAM write data |
| ram_rdata_i | input | SMP_W | RAM read data, one cycle after the strobe |
| mems_we_o | output | 1 | Staging register write strobe |
| mems_idx_o | output | MEMS_IW | Staging register index |
| mems_data_o | output | DATA_W | Staging register data |
| ring_ct_o | output | CT_W | Ring counter |

## Verification
On the last step of a sample, the ring counter update and a memory access fall in the same cycle. The access must still use the old counter value, even though the counter reloads at that edge. The bench provokes this by running many samples with random read and write requests on every step, including the final odd step. It uses small ring masks, so that the reload to mask+1 happens often. Each cycle, a behavioural model computes the address from its own copy of the counter, which it changes only after that cycle's comparison. A design that adds the updated counter therefore shows up as an address mismatch on the final step.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  localparam int DATA_W = 24;
  localparam int SMP_W  = 16;

  function automatic logic [DATA_W-1:0] smp_unpack(input logic [SMP_W-1:0] s);
    return {{(DATA_W-SMP_W){s[SMP_W-1]}}, s};
  endfunction

  function automatic logic [SMP_W-1:0] smp_pack(input logic [DATA_W-1:0] d);
    return d[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/rbuf_offs_table.sv
module rbuf_offs_table #(
  parameter int OFFS_N = 32,
  parameter int RING_W = 16,
  localparam int OFFS_IW = $clog2(OFFS_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [OFFS_IW-1:0] waddr_i,
  input  logic [RING_W-1:0]  wdata_i,
  input  logic [OFFS_IW-1:0] raddr_i,
  output logic [RING_W-1:0]  rdata_o
);
  logic [RING_W-1:0] ent_q [OFFS_N];

  for (genvar g = 0; g < OFFS_N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_q[g] <= '0;
      else if (we_i && waddr_i == OFFS_IW'(g))      ent_q[g] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[raddr_i];
endmodule

// File: rtl/rbuf_addr_gen.sv
module rbuf_addr_gen #(
  parameter int RING_W  = 16,
  parameter int ADRS_W  = 13,
  parameter int BYTE_AW = 21,
  localparam int CT_W   = RING_W + 1,
  localparam int KEEP_W = 12
) (
  input  logic [RING_W-1:0]  offs_i,
  input  logic [ADRS_W-1:0]  adrs_i,
  input  logic               adrs_add_i,
  input  logic               next_adr_i,
  input  logic               abs_table_i,
  input  logic [CT_W-1:0]    ct_i,
  input  logic [RING_W-1:0]  ring_mask_i,
  input  logic [BYTE_AW-1:0] base_i,
  output logic [BYTE_AW-1:0] byte_addr_o
);
  logic [RING_W-1:0] w_adr, w_nxt, w_wrd;

  always_comb begin
    w_adr = offs_i + (adrs_add_i ? RING_W'(adrs_i[KEEP_W-1:0]) : '0);
    w_nxt = w_adr + RING_W'(next_adr_i);
    // ring mode wraps in the circular buffer; table mode is absolute
    w_wrd = abs_table_i ? w_nxt : ((w_nxt + ct_i[RING_W-1:0]) & ring_mask_i);
    byte_addr_o = BYTE_AW'({w_wrd, 1'b0}) + base_i;
  end
endmodule

// File: rtl/rbuf_ring_ctr.sv
module rbuf_ring_ctr #(
  parameter int RING_W = 16,
  localparam int CT_W  = RING_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_end_i,
  input  logic [RING_W-1:0] ring_mask_i,
  output logic [CT_W-1:0]   ct_o
);
  logic [CT_W-1:0] ct_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ct_q <= CT_W'(1);
    else if (smp_end_i) begin
      if (ct_q == CT_W'(1)) ct_q <= CT_W'(ring_mask_i) + CT_W'(1);
      else                  ct_q <= ct_q - CT_W'(1);
    end
  end

  assign ct_o = ct_q;
endmodule

// File: rtl/rbuf_rd_stage.sv
module rbuf_rd_stage
  import rbuf_pkg::*;
#(
  parameter int SLOT_N = 4,
  localparam int SLOT_IW = $clog2(SLOT_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_issue_i,
  input  logic [SLOT_IW-1:0] rd_step_i,
  input  logic [SMP_W-1:0]   rdata_i,
  input  logic [SLOT_IW-1:0] sel_i,
  output logic [DATA_W-1:0]  slot_o
);
  logic [DATA_W-1:0]  slot_q [SLOT_N];
  logic               pend_q;
  logic [SLOT_IW-1:0] dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dst_q  <= '0;
    end else begin
      pend_q <= rd_issue_i;
      // data is collected two steps after issue
      if (rd_issue_i) dst_q <= rd_step_i + SLOT_IW'(2);
    end
  end

  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[g] <= '0;
      else if (pend_q && dst_q == SLOT_IW'(g))     slot_q[g] <= smp_unpack(rdata_i);
    end
  end

  assign slot_o = slot_q[sel_i];
endmodule

// File: rtl/rbuf_mem_addr.sv
module rbuf_mem_addr
  import rbuf_pkg::*;
#(
  parameter int OFFS_N  = 32,
  parameter int STEP_N  = 128,
  parameter int RING_W  = 16,
  parameter int BYTE_AW = 21,
  parameter int ADRS_W  = 13,
  parameter int MEMS_N  = 32,
  localparam int OFFS_IW = $clog2(OFFS_N),
  localparam int STEP_W  = $clog2(STEP_N),
  localparam int MEMS_IW = $clog2(MEMS_N),
  localparam int CT_W    = RING_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               offs_we_i,
  input  logic [OFFS_IW-1:0] offs_waddr_i,
  input  logic [RING_W-1:0]  offs_wdata_i,
  input  logic [RING_W-1:0]  ring_mask_i,
  input  logic [BYTE_AW-1:0] base_ptr_i,
  input  logic               step_valid_i,
  input  logic [STEP_W-1:0]  step_i,
  input  logic [OFFS_IW-1:0] offs_sel_i,
  input  logic               adrs_add_i,
  input  logic               next_adr_i,
  input  logic               abs_table_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic               stage_ld_i,
  input  logic [MEMS_IW-1:0] stage_idx_i,
  input  logic [ADRS_W-1:0]  adrs_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               ram_rd_o,
  output logic               ram_we_o,
  output logic [BYTE_AW-1:0] ram_addr_o,
  output logic [SMP_W-1:0]   ram_wdata_o,
  input  logic [SMP_W-1:0]   ram_rdata_i,
  output logic               mems_we_o,
  output logic [MEMS_IW-1:0] mems_idx_o,
  output logic [DATA_W-1:0]  mems_data_o,
  output logic [CT_W-1:0]    ring_ct_o
);
  localparam int SLOT_N = 4;
  localparam int SLOT_IW = $clog2(SLOT_N);

  logic [RING_W-1:0] offs_val;
  logic              acc_ok, smp_end, rd_issue;
  logic [CT_W-1:0]   ct;

  assign acc_ok   = step_valid_i & step_i[0];
  assign ram_we_o = acc_ok & wr_en_i;
  // single port: a write claims the port over a read
  assign rd_issue = acc_ok & rd_en_i & ~wr_en_i;
  assign ram_rd_o = rd_issue;
  assign smp_end  = step_valid_i && (step_i == STEP_W'(STEP_N - 1));
  assign ram_wdata_o = smp_pack(wr_data_i);
  assign mems_we_o  = step_valid_i & stage_ld_i;
  assign mems_idx_o = stage_idx_i;
  assign ring_ct_o  = ct;

  rbuf_offs_table #(.OFFS_N(OFFS_N), .RING_W(RING_W)) u_offs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (offs_we_i),
    .waddr_i (offs_waddr_i),
    .wdata_i (offs_wdata_i),
    .raddr_i (offs_sel_i),
    .rdata_o (offs_val)
  );

  rbuf_addr_gen #(.RING_W(RING_W), .ADRS_W(ADRS_W), .BYTE_AW(BYTE_AW)) u_agen (
    .offs_i      (offs_val),
    .adrs_i      (adrs_i),
    .adrs_add_i  (adrs_add_i),
    .next_adr_i  (next_adr_i),
    .abs_table_i (abs_table_i),
    .ct_i        (ct),
    .ring_mask_i (ring_mask_i),
    .base_i      (base_ptr_i),
    .byte_addr_o (ram_addr_o)
  );

  rbuf_ring_ctr #(.RING_W(RING_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_end_i   (smp_end),
    .ring_mask_i (ring_mask_i),
    .ct_o        (ct)
  );

  rbuf_rd_stage #(.SLOT_N(SLOT_N)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_issue_i (rd_issue),
    .rd_step_i  (step_i[SLOT_IW-1:0]),
    .rdata_i    (ram_rdata_i),
    .sel_i      (step_i[SLOT_IW-1:0]),
    .slot_o     (mems_data_o)
  );
endmodule

// File: rtl/rbuf_mem_addr_chk.sv
module rbuf_mem_addr_chk #(
  parameter int STEP_N = 128,
  parameter int RING_W = 16,
  localparam int STEP_W = $clog2(STEP_N),
  localparam int CT_W   = RING_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_valid_i,
  input logic [STEP_W-1:0] step_i,
  input logic              ram_rd_o,
  input logic              ram_we_o,
  input logic              mems_we_o,
  input logic [CT_W-1:0]   ring_ct_o
);
  logic last_step;
  assign last_step = step_valid_i && (step_i == STEP_W'(STEP_N - 1));

  a_r7_odd_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_valid_i && !step_i[0]) |-> (!ram_rd_o && !ram_we_o));

  a_r11_port_mutex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_rd_o, ram_we_o}));

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_valid_i |-> (!ram_rd_o && !ram_we_o && !mems_we_o));

  a_r12_ct_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_step |=> $stable(ring_ct_o));

  a_r10_ct_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_ct_o != '0);

  a_r10_ct_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_step && ring_ct_o != CT_W'(1)) |=> (ring_ct_o == $past(ring_ct_o) - CT_W'(1)));
endmodule

bind rbuf_mem_addr rbuf_mem_addr_chk #(.STEP_N(STEP_N), .RING_W(RING_W)) u_chk (.*);

// File: tb/rbuf_mem_addr_tb.sv
`timescale 1ns/1ps
module rbuf_mem_addr_tb;
  localparam int AW = 21;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        offs_we_i = 0;
  logic [4:0]  offs_waddr_i = '0;
  logic [15:0] offs_wdata_i = '0, ring_mask_i = '0;
  logic [AW-1:0] base_ptr_i = '0;
  logic        step_valid_i = 0;
  logic [6:0]  step_i = '0;
  logic [4:0]  offs_sel_i = '0, stage_idx_i = '0;
  logic        adrs_add_i = 0, next_adr_i = 0, abs_table_i = 0;
  logic        rd_en_i = 0, wr_en_i = 0, stage_ld_i = 0;
  logic [12:0] adrs_i = '0;
  logic [23:0] wr_data_i = '0;
  logic        ram_rd_o, ram_we_o, mems_we_o;
  logic [AW-1:0] ram_addr_o;
  logic [15:0] ram_wdata_o, ram_rdata_i;
  logic [4:0]  mems_idx_o;
  logic [23:0] mems_data_o;
  logic [16:0] ring_ct_o;

  int n_cmp = 0, n_err = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  rbuf_mem_addr u_dut (.*);

  // bench RAM, one-cycle read latency
  logic [15:0] ram [int];
  initial ram_rdata_i = '0;
  always @(posedge clk_i) begin
    if (ram_we_o) ram[int'(ram_addr_o)] = ram_wdata_o;
    if (ram_rd_o) ram_rdata_i <= ram.exists(int'(ram_addr_o)) ? ram[int'(ram_addr_o)] : 16'h0;
  end

  // reference model state
  int  m_offs [32];
  int  m_slot [4];
  int  m_mem [int];
  int  m_ct;
  bit  p_pend; int p_slot, p_data;
  bit  e_rd, e_we; int e_addr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int sext16(input int v);
    return (v & 'h8000) ? ((v & 'hFFFF) | 'hFF0000) : (v & 'hFFFF);
  endfunction

  task automatic cycle();
    int w;
    @(negedge clk_i);
    e_we = step_valid_i && step_i[0] && wr_en_i;
    e_rd = step_valid_i && step_i[0] && rd_en_i && !wr_en_i;
    w = m_offs[offs_sel_i];
    if (adrs_add_i) w += int'(adrs_i) & 'hFFF;
    if (next_adr_i) w += 1;
    if (!abs_table_i) w = (w + m_ct) & int'(ring_mask_i);
    w &= 'hFFFF;
    e_addr = (w * 2 + int'(base_ptr_i)) % (1 << AW);
    chk(ram_we_o === e_we, !step_valid_i ? "R12 write strobe" : "R7 write strobe", ram_we_o, e_we);
    chk(ram_rd_o === e_rd, (rd_en_i && wr_en_i) ? "R11 read strobe" :
        (!step_valid_i ? "R12 read strobe" : "R7 read strobe"), ram_rd_o, e_rd);
    if (e_rd || e_we)
      chk(int'(ram_addr_o) == e_addr, abs_table_i ? "R2 R3 R5 R6 address" : "R2 R3 R4 R6 address",
          int'(ram_addr_o), e_addr);
    if (e_we) chk(int'(ram_wdata_o) == (int'(wr_data_i) & 'hFFFF), "R8 write data",
                  int'(ram_wdata_o), int'(wr_data_i) & 'hFFFF);
    chk(mems_we_o === (step_valid_i && stage_ld_i), "R9 staging strobe", mems_we_o, step_valid_i && stage_ld_i);
    if (step_valid_i && stage_ld_i) begin
      chk(mems_idx_o == stage_idx_i, "R9 staging index", mems_idx_o, stage_idx_i);
      chk(int'(mems_data_o) == m_slot[step_i[1:0]], "R9 staging data", int'(mems_data_o), m_slot[step_i[1:0]]);
    end
    chk(int'(ring_ct_o) == m_ct, "R10 ring counter", int'(ring_ct_o), m_ct);
    @(posedge clk_i);
    if (p_pend) m_slot[p_slot] = p_data;
    p_pend = e_rd;
    if (e_rd) begin
      p_slot = (int'(step_i) + 2) % 4;
      p_data = sext16(m_mem.exists(e_addr) ? m_mem[e_addr] : 0);
    end
    if (e_we) m_mem[e_addr] = int'(wr_data_i) & 'hFFFF;
    if (offs_we_i) m_offs[offs_waddr_i] = int'(offs_wdata_i);
    if (step_valid_i && step_i == 7'd127) m_ct = (m_ct == 1) ? int'(ring_mask_i) + 1 : m_ct - 1;
    #1;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL R10 watchdog expired act=0 exp=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    int s;
    foreach (m_offs[i]) m_offs[i] = 0;
    foreach (m_slot[i]) m_slot[i] = 0;
    m_ct = 1; p_pend = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(ring_ct_o == 17'd1, "R1 counter after reset", int'(ring_ct_o), 1);
    chk(!ram_rd_o && !ram_we_o && !mems_we_o, "R1 idle after reset",
        int'({ram_rd_o, ram_we_o, mems_we_o}), 0);
    @(posedge clk_i); #1;
    // R1 slots at zero, R5 table address with zero offset
    step_valid_i = 1; step_i = 7'd2; stage_ld_i = 1; cycle();
    stage_ld_i = 0; step_valid_i = 0;
    // R2 offset table load; R12 nothing issued meanwhile
    for (int i = 0; i < 32; i++) begin
      offs_we_i = 1; offs_waddr_i = 5'(i); offs_wdata_i = 16'($urandom);
      rd_en_i = 1; wr_en_i = i[0]; step_i = 7'(i);
      cycle();
    end
    offs_we_i = 0;
    for (int smp = 0; smp < 48; smp++) begin
      case (smp % 4)
        0: ring_mask_i = 16'h0003;
        1: ring_mask_i = 16'h00FF;
        2: ring_mask_i = 16'hFFFF;
        default: ring_mask_i = 16'h0000;
      endcase
      base_ptr_i = AW'($urandom);
      s = 0;
      while (s < 128) begin
        step_valid_i = ($urandom % 10) != 0;        // R12 gaps
        step_i       = 7'(s);
        offs_sel_i   = 5'($urandom);
        adrs_add_i   = $urandom % 2;                 // R3
        next_adr_i   = $urandom % 2;                 // R3
        abs_table_i  = ($urandom % 3) == 0;          // R4 R5
        rd_en_i      = ($urandom % 3) != 0;          // R7 on even steps too
        wr_en_i      = ($urandom % 4) == 0;          // R11 when both
        stage_ld_i   = $urandom % 2;
        stage_idx_i  = 5'($urandom);
        adrs_i       = 13'($urandom);
        wr_data_i    = 24'($urandom);
        cycle();
        if (step_valid_i) s++;
      end
    end
    step_valid_i = 0;
    cycle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule